// File: doc/BRIEF.md
# Package Activity Residency Monitor

This block watches a busy/idle flag from each of the cores in a package and samples the joint pattern on every clock. Each sample puts the package in one of three classes: every core busy, every core idle, or a mix of both. Over a fixed observation slot the block counts how many cycles fell into each class. When a slot ends it publishes the three counts, raises a one-cycle strobe and starts the next slot at once. The counts feed a workload predictor and a power-management controller downstream.

The slot length is a cycle count on an input port. It is normally set to 500 µs at the operating clock, which is 62,500 cycles at 125 MHz. An optional location-aware mode, selected by a parameter, also counts every one of the 2^N individual core patterns. The core flags are asynchronous to the block and pass through a two-flop synchroniser before they are classified.

Top module: `activity_residency_monitor`

## Requirements
- R1: A cycle counts as all-busy only when every synchronised core flag is 1 (1 means busy).
- R2: A cycle counts as all-idle only when every synchronised core flag is 0.
- R3: Every other pattern counts as partially idle: at least one core busy and at least one idle. That covers 2^N−2 patterns.
- R4: A slot lasts `slot_len` cycles, and a value of 0 or 1 gives a one-cycle slot. The length is compared live against the cycles elapsed, so lowering it below the elapsed count ends the slot on the next cycle. The three published counts always sum to the length of the slot just ended.
- R5: At the last cycle of a slot the block publishes the counts, including that cycle's sample. `res_valid` is high for exactly the following cycle, provided the next slot is longer than one cycle. The accumulators restart in the same cycle, so no sample is lost or counted twice.
- R6: Between strobes the published counts hold their values.
- R7: Each core flag passes through two flip-flops. A change at the input is counted from the second clock edge after it is captured. The synchroniser resets to all idle, so the first two samples after reset count as all-idle.
- R8: When `LOC_EN` is 1, `res_pat` holds one count per pattern. Slice i (`res_pat[i*SLOT_W +: SLOT_W]`) counts the cycles whose synchronised pattern equals i, where bit j of i is core j. Pattern 0 equals the all-idle count and pattern 2^N−1 equals the all-busy count.
- R9: After reset all published counts are zero. `res_valid` stays low until the first full slot after reset release completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_busy | input | N_CORES | Busy flag per core, 1 = busy, asynchronous |
| slot_len | input | SLOT_W | Slot length in cycles |
| res_valid | output | 1 | One-cycle strobe: new counts published |
| res_busy | output | SLOT_W | All-busy cycles in the last slot |
| res_idle | output | SLOT_W | All-idle cycles in the last slot |
| res_part | output | SLOT_W | Partially idle cycles in the last slot |
| res_pat | output | 2^N_CORES × SLOT_W | Per-pattern cycle counts for the last slot |

## Verification
The classifier is driven with all four two-core patterns, in runs of varied length that straddle slot boundaries. This shows whether each mixed pattern lands in the partial class, and whether the all-ones and all-zeros patterns stay apart from it. Single-cycle runs placed right at a boundary show whether the sample of a slot's last cycle goes to that slot and is never repeated in the next one. Holding the flags all busy through reset tells apart a correct two-cycle synchroniser delay from a shorter or longer one. A zero or one slot length and a mid-slot reduction of the length probe the end-of-slot compare.

// File: rtl/arm_pkg.sv
package arm_pkg;

  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_PART = 2'd1,
    CLS_BUSY = 2'd2
  } act_class_e;

  localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/arm_sync.sv
module arm_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/arm_classify.sv
module arm_classify import arm_pkg::*; #(
  parameter int N_CORES = 2,
  localparam int NPAT   = 1 << N_CORES
) (
  input  logic [N_CORES-1:0]     pattern,
  output logic [NUM_CLASSES-1:0] cls_hit,
  output logic [NPAT-1:0]        pat_hit
);

  logic every_busy;
  logic every_idle;

  always_comb begin
    every_busy = &pattern;
    every_idle = ~|pattern;
    cls_hit             = '0;
    cls_hit[CLS_BUSY]   = every_busy;
    cls_hit[CLS_IDLE]   = every_idle;
    cls_hit[CLS_PART]   = !every_busy && !every_idle;
  end

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    assign pat_hit[p] = (pattern == N_CORES'(p));
  end

endmodule

// File: rtl/arm_slot_timer.sv
module arm_slot_timer #(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_len,
  output logic              slot_end,
  output logic              strobe
);

  logic [SLOT_W-1:0] elapsed_q, elapsed_d;
  logic              strobe_q, strobe_d;
  logic [SLOT_W:0]   eff_len;
  logic [SLOT_W:0]   next_cnt;

  always_comb begin
    eff_len   = (slot_len == '0) ? (SLOT_W+1)'(1) : {1'b0, slot_len};
    next_cnt  = {1'b0, elapsed_q} + (SLOT_W+1)'(1);
    slot_end  = (next_cnt >= eff_len);
    elapsed_d = slot_end ? '0 : next_cnt[SLOT_W-1:0];
    strobe_d  = slot_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      strobe_q  <= 1'b0;
    end else begin
      elapsed_q <= elapsed_d;
      strobe_q  <= strobe_d;
    end
  end

  assign strobe = strobe_q;

endmodule

// File: rtl/arm_accum.sv
module arm_accum #(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              slot_end,
  output logic [SLOT_W-1:0] result
);

  logic [SLOT_W-1:0] acc_q, acc_d;
  logic [SLOT_W-1:0] res_q, res_d;
  logic [SLOT_W-1:0] acc_inc;
  logic              res_en;

  always_comb begin
    acc_inc = acc_q + SLOT_W'(hit);
    res_en  = slot_end;
    acc_d   = slot_end ? '0 : acc_inc;
    res_d   = res_en ? acc_inc : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/activity_residency_monitor.sv
module activity_residency_monitor import arm_pkg::*; #(
  parameter int N_CORES = 2,
  parameter int SLOT_W  = 16,
  parameter bit LOC_EN  = 1'b1,
  localparam int NPAT   = 1 << N_CORES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CORES-1:0]     core_busy,
  input  logic [SLOT_W-1:0]      slot_len,
  output logic                   res_valid,
  output logic [SLOT_W-1:0]      res_busy,
  output logic [SLOT_W-1:0]      res_idle,
  output logic [SLOT_W-1:0]      res_part,
  output logic [NPAT*SLOT_W-1:0] res_pat
);

  logic [N_CORES-1:0]     core_sync;
  logic [NUM_CLASSES-1:0] cls_hit;
  logic [NPAT-1:0]        pat_hit;
  logic                   slot_end;
  logic [SLOT_W-1:0]      cls_res [NUM_CLASSES];

  arm_sync #(.WIDTH(N_CORES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (core_busy),
    .sync_out (core_sync)
  );

  arm_classify #(.N_CORES(N_CORES)) u_cls (
    .pattern (core_sync),
    .cls_hit (cls_hit),
    .pat_hit (pat_hit)
  );

  arm_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_len (slot_len),
    .slot_end (slot_end),
    .strobe   (res_valid)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    arm_accum #(.SLOT_W(SLOT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (cls_hit[c]),
      .slot_end (slot_end),
      .result   (cls_res[c])
    );
  end

  assign res_busy = cls_res[CLS_BUSY];
  assign res_idle = cls_res[CLS_IDLE];
  assign res_part = cls_res[CLS_PART];

  if (LOC_EN) begin : g_loc
    for (genvar p = 0; p < NPAT; p++) begin : g_pat
      arm_accum #(.SLOT_W(SLOT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (pat_hit[p]),
        .slot_end (slot_end),
        .result   (res_pat[p*SLOT_W +: SLOT_W])
      );
    end
  end else begin : g_noloc
    assign res_pat = '0;
  end

endmodule

// File: rtl/arm_checker.sv
module arm_checker #(
  parameter int N_CORES = 2,
  parameter int SLOT_W  = 16,
  parameter bit LOC_EN  = 1'b1,
  localparam int NPAT   = 1 << N_CORES
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SLOT_W-1:0]      slot_len,
  input logic                   res_valid,
  input logic [SLOT_W-1:0]      res_busy,
  input logic [SLOT_W-1:0]      res_idle,
  input logic [SLOT_W-1:0]      res_part,
  input logic [NPAT*SLOT_W-1:0] res_pat
);

  logic [SLOT_W+1:0]       class_sum;
  logic [SLOT_W+N_CORES:0] pat_sum;

  always_comb begin
    class_sum = (SLOT_W+2)'(res_busy) + (SLOT_W+2)'(res_idle) + (SLOT_W+2)'(res_part);
    pat_sum   = '0;
    for (int p = 0; p < NPAT; p++)
      pat_sum = pat_sum + (SLOT_W+N_CORES+1)'(res_pat[p*SLOT_W +: SLOT_W]);
  end

  // R4
  nonempty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> class_sum != '0);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $stable(slot_len) && slot_len > SLOT_W'(1)) |=> !res_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({res_busy, res_idle, res_part}) |-> res_valid);

  if (LOC_EN) begin : g_loc_chk
    // R8
    pat_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_busy == res_pat[(NPAT-1)*SLOT_W +: SLOT_W]);

    // R8
    pat_idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_idle == res_pat[0 +: SLOT_W]);

    // R4
    pat_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (SLOT_W+N_CORES+1)'(class_sum) == pat_sum);
  end

endmodule

bind activity_residency_monitor arm_checker #(
  .N_CORES (N_CORES),
  .SLOT_W  (SLOT_W),
  .LOC_EN  (LOC_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_len  (slot_len),
  .res_valid (res_valid),
  .res_busy  (res_busy),
  .res_idle  (res_idle),
  .res_part  (res_part),
  .res_pat   (res_pat)
);

// File: tb/activity_residency_monitor_tb.sv
module activity_residency_monitor_tb;

  localparam int N    = 2;
  localparam int W    = 12;
  localparam int NP   = 4;
  localparam int L    = 16;
  localparam int NVEC = 12;

  // {pattern[11:10], class[9:8] (0 idle,1 partial,2 busy), hold cycles[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b11, 2'd2, 8'd7},  {2'b00, 2'd0, 8'd5},  {2'b01, 2'd1, 8'd3},
    {2'b10, 2'd1, 8'd9},  {2'b11, 2'd2, 8'd12}, {2'b00, 2'd0, 8'd20},
    {2'b01, 2'd1, 8'd4},  {2'b10, 2'd1, 8'd6},  {2'b11, 2'd2, 8'd1},
    {2'b00, 2'd0, 8'd1},  {2'b01, 2'd1, 8'd1},  {2'b11, 2'd2, 8'd18}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    core_busy;
  logic [W-1:0]    slot_len;
  logic            res_valid;
  logic [W-1:0]    res_busy, res_idle, res_part;
  logic [NP*W-1:0] res_pat;
  logic [1:0]      drv_cls;
  bit              run_chk = 1'b0;
  int              checks = 0;
  int              errors = 0;

  always #4 clk = ~clk;

  activity_residency_monitor #(.N_CORES(N), .SLOT_W(W), .LOC_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_busy(core_busy), .slot_len(slot_len),
    .res_valid(res_valid), .res_busy(res_busy), .res_idle(res_idle),
    .res_part(res_part), .res_pat(res_pat)
  );

  // Reference: two-stage delay of the driven stimulus, per-class accumulation per slot
  logic [N-1:0] m_p1, m_p2;
  logic [1:0]   m_c1, m_c2;
  int           m_pos;
  int           m_acc [3];
  int           m_pac [NP];
  int           e_cls [3];
  int           e_pat [NP];
  bit           e_valid;

  always @(posedge clk or negedge rst_n) begin
    int eff;
    if (!rst_n) begin
      m_p1 = '0; m_p2 = '0; m_c1 = 2'd0; m_c2 = 2'd0; m_pos = 0; e_valid = 0;
      for (int i = 0; i < 3; i++) begin m_acc[i] = 0; e_cls[i] = 0; end
      for (int i = 0; i < NP; i++) begin m_pac[i] = 0; e_pat[i] = 0; end
    end else begin
      eff = (slot_len == 0) ? 1 : int'(slot_len);
      m_acc[m_c2]++;
      m_pac[m_p2]++;
      if (m_pos + 1 >= eff) begin
        e_cls = m_acc; e_pat = m_pac;
        for (int i = 0; i < 3; i++) m_acc[i] = 0;
        for (int i = 0; i < NP; i++) m_pac[i] = 0;
        m_pos = 0; e_valid = 1;
      end else begin
        m_pos++; e_valid = 0;
      end
      m_p2 = m_p1; m_c2 = m_c1;
      m_p1 = core_busy; m_c1 = drv_cls;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk("R5 strobe timing", res_valid, e_valid);
      chk(e_valid ? "R1 busy count" : "R6 busy held", res_busy, e_cls[2]);
      chk(e_valid ? "R2 idle count" : "R6 idle held", res_idle, e_cls[0]);
      chk(e_valid ? "R3 partial count" : "R6 partial held", res_part, e_cls[1]);
      for (int p = 0; p < NP; p++)
        chk("R8 pattern count", res_pat[p*W +: W], e_pat[p]);
      if (res_valid)
        chk("R4 class sum", res_busy + res_idle + res_part,
            e_cls[0] + e_cls[1] + e_cls[2]);
    end
  end

  task automatic drive(input logic [N-1:0] pat, input logic [1:0] cls);
    core_busy = pat;
    drv_cls   = cls;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    slot_len = W'(L);
    drive(2'b11, 2'd2);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset valid", res_valid, 0);
    chk("R9 reset busy", res_busy, 0);
    chk("R9 reset idle", res_idle, 0);
    chk("R9 reset pattern", res_pat, 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (L - 1) @(negedge clk);
    chk("R9 no strobe before first slot", res_valid, 0);
    @(negedge clk);
    chk("R9 first strobe", res_valid, 1);
    chk("R7 two idle samples after reset", res_idle, 2);
    chk("R7 busy after sync delay", res_busy, L - 2);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][11:10], VEC[v][9:8]);
      repeat (int'(VEC[v][7:0])) @(negedge clk);
    end
    repeat (L) @(negedge clk);

    // R4 slot length of one and zero
    slot_len = W'(1);
    drive(2'b01, 2'd1);
    repeat (2) @(negedge clk);
    chk("R4 length one strobe", res_valid, 1);
    chk("R4 length one sum", res_busy + res_idle + res_part, 1);
    slot_len = '0;
    drive(2'b00, 2'd0);
    repeat (4) @(negedge clk);
    chk("R4 length zero strobe", res_valid, 1);
    chk("R4 length zero idle", res_idle, 1);

    // R4 live shrink of slot length
    slot_len = W'(40);
    drive(2'b10, 2'd1);
    repeat (10) @(negedge clk);
    chk("R4 no strobe mid long slot", res_valid, 0);
    slot_len = W'(4);
    @(negedge clk);
    chk("R4 shrink ends slot", res_valid, 1);
    chk("R4 shrink sum", res_busy + res_idle + res_part, 11);
    slot_len = W'(L);
    repeat (2 * L + 3) @(negedge clk);

    // R9 reset mid-slot
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset busy", res_busy, 0);
    chk("R9 mid reset partial", res_part, 0);
    rst_n = 1'b1;
    repeat (L + 2) @(negedge clk);
    run_chk = 1'b0;
    finish_run();
  end

endmodule